// File: doc/BRIEF.md
# Symbol Timing Oscillator with Serial Offset Loading

This block is a numerically controlled oscillator that paces symbol timing in a receive path. A 32-bit phase accumulator advances every clock by an active center-frequency word and, when enabled, by an offset-frequency word. The offset word arrives one bit per clock on a serial pin. A separate framing pin marks the start of each word, and a 2-bit code sets how many bits make up the word. Each wrap of the accumulator raises a one-cycle timing strobe. A phase-select byte is formed from the top byte of the accumulator plus an 8-bit phase offset.

The center frequency and the phase offset are written into pending registers through plain write ports. They reach the oscillator only when their own update strobe is pulsed. Several controls can restart the accumulator: a clear bit that holds it at zero, a load-on-update bit that restarts it at zero when a new frequency becomes active, and an external sync pin that restarts it at zero when that feature is enabled. The serial framing pin and the external sync pin are asynchronous. Each passes through a two-flip-flop synchronizer, and only its rising edge is used.

Every pin is a plain control or data level. There is no valid/ready stream at this boundary, so there is no back-pressure. Serial bits are consumed at one per clock and cannot be held off.

Top module: `timing_nco_top`

## Requirements
- R1: After reset the accumulator reads zero, the timing strobe is low, the phase-select output is zero, and the active center frequency and active phase offset are zero.
- R2: With the offset disabled and no restart condition, the accumulator grows by exactly the active center frequency every clock, modulo 2^32.
- R3: With ctl_offset_en high, the accumulator grows by the active center frequency plus the last completed offset word every clock, modulo 2^32.
- R4: The serial framing and bit pins each pass through two flip-flops. The bit presented with the framing pin's rising edge is the MSB, and one bit follows per clock. Width code 00 selects 8 bits, 01 selects 16, 10 selects 24 and 11 selects 32. The received bits are left-justified into the 32-bit offset word with zeros below them. The new offset applies from the edge that captures the last bit, which is the clock edge two cycles after that bit is presented.
- R5: While ctl_clear is high the accumulator is zero and the strobe is low. Clear outranks external sync, which outranks load-on-update, which outranks normal advance.
- R6: A pulse on freq_upd copies the pending center frequency into the active register. A write on freq_wr alone leaves the accumulator step unchanged.
- R7: When freq_upd arrives with ctl_load_on_update high, the accumulator is zero after that edge. When ctl_load_on_update is low, the accumulator keeps advancing using the previous frequency on that edge.
- R8: With ctl_ext_sync_en high, a rising edge on ext_sync leaves the accumulator at zero after the third clock edge following it. With ctl_ext_sync_en low, the pin has no effect.
- R9: timing_strobe is high for exactly the one cycle following an edge on which the accumulator sum carries out of bit 31.
- R10: filt_phase equals accumulator bits 31:24 plus the active phase offset, modulo 256. A pulse on phase_upd copies the pending phase offset into the active register, and a write on phase_wr alone does not change filt_phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_clear | input | 1 | Hold the accumulator at zero |
| ctl_offset_en | input | 1 | Add the offset word to each step |
| ctl_load_on_update | input | 1 | Restart the accumulator when a frequency update takes effect |
| ctl_ext_sync_en | input | 1 | Allow ext_sync to restart the accumulator |
| ctl_width | input | 2 | Offset word length code (00=8, 01=16, 10=24, 11=32 bits) |
| freq_wr | input | 1 | Write freq_wdata into the pending center frequency |
| freq_wdata | input | 32 | Pending center-frequency data |
| freq_upd | input | 1 | Make the pending center frequency active |
| phase_wr | input | 1 | Write phase_wdata into the pending phase offset |
| phase_wdata | input | 8 | Pending phase-offset data |
| phase_upd | input | 1 | Make the pending phase offset active |
| ser_sync | input | 1 | Asynchronous framing pin; its rising edge starts a word |
| ser_data | input | 1 | Serial offset bits, MSB first |
| ext_sync | input | 1 | Asynchronous external restart pin |
| acc_phase | output | 32 | Accumulator value |
| timing_strobe | output | 1 | One-cycle carry-out pulse |
| filt_phase | output | 8 | Phase-select value |

## Verification
Two events can land on the same clock edge: a frequency update and the completion of a serial offset word. The bench counts the synchronizer delay so that the edge capturing the last serial bit is also the edge that sees freq_upd. It then measures two accumulator steps. The step across that shared edge must use both old words. The step after it must equal the new center frequency plus the new left-justified offset. If either word is dropped or delayed, the measured step shows it.

// File: rtl/tnco_pkg.sv
package tnco_pkg;
  // offset word length code, selects a quarter-multiple of the word width
  typedef logic [1:0] wcode_t;

  function automatic int code_bits(input wcode_t c, input int word_w);
    return (int'(c) + 1) * (word_w / 4);
  endfunction
endpackage

// File: rtl/tnco_sync.sv
module tnco_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o,
  output logic rise_o
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain[STAGES-1];

  assign q_o    = chain[STAGES-1];
  assign rise_o = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/tnco_serial_rx.sv
module tnco_serial_rx
  import tnco_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         bit_i,
  input  wcode_t       wcode_i,
  output logic [W-1:0] off_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  sh_q;
  logic [W-1:0]  sh_n;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] len_q;
  logic          busy_q;

  assign sh_n = {sh_q[W-2:0], bit_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      len_q  <= '0;
      busy_q <= 1'b0;
      off_o  <= '0;
    end else if (start_i) begin
      // first (MSB) bit arrives with the framing edge; length latched here
      sh_q   <= {{(W-1){1'b0}}, bit_i};
      cnt_q  <= CW'(1);
      len_q  <= CW'(code_bits(wcode_i, W));
      busy_q <= 1'b1;
    end else if (busy_q) begin
      sh_q <= sh_n;
      if (cnt_q + CW'(1) == len_q) begin
        off_o  <= sh_n << (W - int'(len_q));
        busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end
endmodule

// File: rtl/tnco_accum.sv
module tnco_accum #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         restart_i,
  input  logic [W-1:0] freq_i,
  input  logic [W-1:0] off_i,
  input  logic         off_en_i,
  output logic [W-1:0] acc_o,
  output logic         carry_o
);
  logic [W+1:0] sum;

  always_comb begin
    sum = {2'b00, acc_o} + {2'b00, freq_i};
    if (off_en_i) sum = sum + {2'b00, off_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_o   <= '0;
      carry_o <= 1'b0;
    end else if (clear_i || restart_i) begin
      acc_o   <= '0;
      carry_o <= 1'b0;
    end else begin
      acc_o   <= sum[W-1:0];
      carry_o <= |sum[W+1:W];
    end
  end
endmodule

// File: rtl/timing_nco_top.sv
module timing_nco_top
  import tnco_pkg::*;
#(
  parameter int ACC_W       = 32,
  parameter int PO_W        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_clear,
  input  logic             ctl_offset_en,
  input  logic             ctl_load_on_update,
  input  logic             ctl_ext_sync_en,
  input  logic [1:0]       ctl_width,
  input  logic             freq_wr,
  input  logic [ACC_W-1:0] freq_wdata,
  input  logic             freq_upd,
  input  logic             phase_wr,
  input  logic [PO_W-1:0]  phase_wdata,
  input  logic             phase_upd,
  input  logic             ser_sync,
  input  logic             ser_data,
  input  logic             ext_sync,
  output logic [ACC_W-1:0] acc_phase,
  output logic             timing_strobe,
  output logic [PO_W-1:0]  filt_phase
);
  logic [ACC_W-1:0] cf_pend, cf_act;
  logic [PO_W-1:0]  po_pend, po_act;
  logic [ACC_W-1:0] off_word;
  logic             fr_rise, fr_lvl;
  logic             ext_rise, ext_lvl;
  logic             sd_rise, sd_lvl;
  logic             restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cf_pend <= '0;
      cf_act  <= '0;
      po_pend <= '0;
      po_act  <= '0;
    end else begin
      if (freq_wr)   cf_pend <= freq_wdata;
      if (freq_upd)  cf_act  <= cf_pend;
      if (phase_wr)  po_pend <= phase_wdata;
      if (phase_upd) po_act  <= po_pend;
    end
  end

  tnco_sync #(.STAGES(SYNC_STAGES)) u_sync_frame (
    .clk(clk), .rst_n(rst_n), .d_i(ser_sync), .q_o(fr_lvl), .rise_o(fr_rise)
  );
  tnco_sync #(.STAGES(SYNC_STAGES)) u_sync_data (
    .clk(clk), .rst_n(rst_n), .d_i(ser_data), .q_o(sd_lvl), .rise_o(sd_rise)
  );
  tnco_sync #(.STAGES(SYNC_STAGES)) u_sync_ext (
    .clk(clk), .rst_n(rst_n), .d_i(ext_sync), .q_o(ext_lvl), .rise_o(ext_rise)
  );

  tnco_serial_rx #(.W(ACC_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .start_i(fr_rise), .bit_i(sd_lvl),
    .wcode_i(wcode_t'(ctl_width)), .off_o(off_word)
  );

  // restart sources below clear; external sync outranks load-on-update
  assign restart = (ctl_ext_sync_en && ext_rise) ||
                   (freq_upd && ctl_load_on_update);

  tnco_accum #(.W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clear_i(ctl_clear), .restart_i(restart),
    .freq_i(cf_act), .off_i(off_word), .off_en_i(ctl_offset_en),
    .acc_o(acc_phase), .carry_o(timing_strobe)
  );

  assign filt_phase = acc_phase[ACC_W-1 -: PO_W] + po_act;

  // level outputs of some synchronizers are not needed downstream
  logic unused_ok;
  assign unused_ok = fr_lvl ^ sd_rise ^ ext_lvl;
endmodule

// File: rtl/tnco_chk.sv
module tnco_chk #(
  parameter int ACC_W = 32,
  parameter int PO_W  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_clear,
  input logic             ctl_offset_en,
  input logic             ctl_load_on_update,
  input logic             ctl_ext_sync_en,
  input logic             freq_upd,
  input logic             phase_upd,
  input logic [ACC_W-1:0] acc_phase,
  input logic             timing_strobe,
  input logic [ACC_W-1:0] cf_act,
  input logic [PO_W-1:0]  po_act
);
  // R2: plain advance by the active frequency
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_clear && !ctl_offset_en && !freq_upd && !ctl_ext_sync_en)
    |=> acc_phase == $past(acc_phase) + $past(cf_act));

  // R5: clear holds zero and no strobe
  a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_clear |=> (acc_phase == '0) && !timing_strobe);

  // R7: load on update restarts the accumulator
  a_r7_load_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_upd && ctl_load_on_update && !ctl_clear) |=> acc_phase == '0);

  // R6: active frequency moves only on its strobe
  a_r6_freq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !freq_upd |=> $stable(cf_act));

  // R10: active phase offset moves only on its strobe
  a_r10_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_upd |=> $stable(po_act));

  // R9: a strobe without offset means the accumulator wrapped
  a_r9_strobe_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (timing_strobe && !$past(ctl_offset_en)) |-> acc_phase < $past(acc_phase));
endmodule

bind timing_nco_top tnco_chk #(.ACC_W(ACC_W), .PO_W(PO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_clear(ctl_clear),
  .ctl_offset_en(ctl_offset_en), .ctl_load_on_update(ctl_load_on_update),
  .ctl_ext_sync_en(ctl_ext_sync_en), .freq_upd(freq_upd),
  .phase_upd(phase_upd), .acc_phase(acc_phase),
  .timing_strobe(timing_strobe), .cf_act(cf_act), .po_act(po_act)
);

// File: tb/tb_timing_nco_top.sv
module tb_timing_nco_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_clear = 1'b0, ctl_offset_en = 1'b0;
  logic        ctl_load_on_update = 1'b0, ctl_ext_sync_en = 1'b0;
  logic [1:0]  ctl_width = 2'b00;
  logic        freq_wr = 1'b0, freq_upd = 1'b0;
  logic [31:0] freq_wdata = '0;
  logic        phase_wr = 1'b0, phase_upd = 1'b0;
  logic [7:0]  phase_wdata = '0;
  logic        ser_sync = 1'b0, ser_data = 1'b0, ext_sync = 1'b0;
  logic [31:0] acc_phase;
  logic        timing_strobe;
  logic [7:0]  filt_phase;

  int n_checks = 0;
  int n_errs   = 0;

  timing_nco_top dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_freq(input logic [31:0] v);
    freq_wr = 1'b1; freq_wdata = v; tick(); freq_wr = 1'b0;
  endtask

  task automatic apply_freq(input logic [31:0] v);
    write_freq(v);
    freq_upd = 1'b1; tick(); freq_upd = 1'b0;
  endtask

  function automatic logic [31:0] just(input logic [31:0] v, input logic [1:0] c);
    int n = (int'(c) + 1) * 8;
    return (n == 32) ? v : ((v >> (32 - n)) << (32 - n));
  endfunction

  task automatic step_is(input logic [31:0] exp, input string tag);
    logic [31:0] a;
    a = acc_phase; tick();
    chk(acc_phase - a == exp, tag, acc_phase - a, exp);
  endtask

  task automatic t_reset();
    chk(acc_phase == 0, "R1 acc", acc_phase, 0);
    chk(timing_strobe == 0, "R1 strobe", 32'(timing_strobe), 0);
    chk(filt_phase == 0, "R1 filt", 32'(filt_phase), 0);
    step_is(32'h0, "R1 active freq zero");
  endtask

  task automatic t_step();
    apply_freq(32'h0012_3456);
    step_is(32'h0012_3456, "R2 step a");
    apply_freq(32'hF000_0001);
    step_is(32'hF000_0001, "R2 step b");
    write_freq(32'h0000_0777);
    step_is(32'hF000_0001, "R6 pending write no effect");
    freq_upd = 1'b1; tick(); freq_upd = 1'b0;
    step_is(32'h0000_0777, "R6 update applies");
  endtask

  task automatic t_load();
    logic [31:0] a;
    write_freq(32'h0000_1000);
    ctl_load_on_update = 1'b0;
    a = acc_phase; freq_upd = 1'b1; tick(); freq_upd = 1'b0;
    chk(acc_phase == a + 32'h777, "R7 no load keeps running", acc_phase, a + 32'h777);
    step_is(32'h0000_1000, "R7 new freq after update");
    write_freq(32'h0000_2000);
    ctl_load_on_update = 1'b1;
    freq_upd = 1'b1; tick(); freq_upd = 1'b0;
    chk(acc_phase == 0, "R7 load restarts", acc_phase, 0);
    tick();
    chk(acc_phase == 32'h2000, "R7 first step after load", acc_phase, 32'h2000);
    ctl_load_on_update = 1'b0;
  endtask

  task automatic t_clear_strobe();
    ctl_clear = 1'b1;
    apply_freq(32'h4000_0000);
    chk(acc_phase == 0, "R5 clear holds zero", acc_phase, 0);
    chk(timing_strobe == 0, "R5 clear strobe low", 32'(timing_strobe), 0);
    ctl_clear = 1'b0;
    for (int i = 1; i <= 5; i++) begin
      tick();
      chk(timing_strobe == (i == 4), "R9 strobe on wrap", 32'(timing_strobe), 32'(i == 4));
    end
    ctl_clear = 1'b1; ctl_ext_sync_en = 1'b1; ctl_load_on_update = 1'b1;
    freq_upd = 1'b1; tick(); freq_upd = 1'b0;
    chk(acc_phase == 0, "R5 clear priority", acc_phase, 0);
    ctl_clear = 1'b0; ctl_ext_sync_en = 1'b0; ctl_load_on_update = 1'b0;
  endtask

  task automatic t_phase();
    apply_freq(32'h0100_0000);
    phase_wr = 1'b1; phase_wdata = 8'hF8; tick(); phase_wr = 1'b0;
    chk(filt_phase == acc_phase[31:24], "R10 pending phase no effect",
        32'(filt_phase), 32'(acc_phase[31:24]));
    phase_upd = 1'b1; tick(); phase_upd = 1'b0;
    for (int i = 0; i < 10; i++) begin
      chk(filt_phase == 8'(acc_phase[31:24] + 8'hF8), "R10 phase sum",
          32'(filt_phase), 32'(8'(acc_phase[31:24] + 8'hF8)));
      tick();
    end
  endtask

  task automatic send_word(input logic [31:0] v, input logic [1:0] c);
    int n = (int'(c) + 1) * 8;
    ctl_width = c;
    for (int i = 0; i < n; i++) begin
      ser_sync = (i == 0);
      ser_data = v[31-i];
      tick();
    end
    ser_sync = 1'b0; ser_data = 1'b0;
  endtask

  task automatic t_serial();
    apply_freq(32'h0000_0100);
    ctl_offset_en = 1'b1;
    send_word(32'hA5FF_FFFF, 2'b00); repeat (3) tick();
    step_is(32'h100 + just(32'hA5FF_FFFF, 2'b00), "R4 width 8 left-justified");
    send_word(32'h1234_56FF, 2'b10); repeat (3) tick();
    step_is(32'h100 + just(32'h1234_56FF, 2'b10), "R4 width 24");
    send_word(32'h8000_0003, 2'b11); repeat (3) tick();
    step_is(32'h100 + 32'h8000_0003, "R3 width 32 offset added");
    ctl_offset_en = 1'b0;
    step_is(32'h100, "R3 offset disabled");
  endtask

  task automatic t_coincide();
    logic [31:0] newoff;
    newoff = just(32'hC3C3_0000, 2'b01);
    ctl_offset_en = 1'b1;
    write_freq(32'h0000_0050);
    send_word(32'hC3C3_0000, 2'b01);
    step_is(32'h100 + 32'h8000_0003, "R4 old offset before completion");
    freq_upd = 1'b1;
    step_is(32'h100 + 32'h8000_0003, "R6 shared edge uses old words");
    freq_upd = 1'b0;
    step_is(32'h50 + newoff, "R3 new freq and offset together");
    ctl_offset_en = 1'b0;
  endtask

  task automatic t_ext();
    ctl_ext_sync_en = 1'b0;
    ext_sync = 1'b1; tick(); ext_sync = 1'b0; tick();
    step_is(32'h50, "R8 disabled ignored a");
    step_is(32'h50, "R8 disabled ignored b");
    step_is(32'h50, "R8 disabled ignored c");
    ctl_ext_sync_en = 1'b1;
    ext_sync = 1'b1; tick(); ext_sync = 1'b0; tick(); tick();
    chk(acc_phase == 0, "R8 restart after three edges", acc_phase, 0);
    tick();
    chk(acc_phase == 32'h50, "R8 run after restart", acc_phase, 32'h50);
    ctl_ext_sync_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_step();
    t_load();
    t_clear_strobe();
    t_phase();
    t_serial();
    t_coincide();
    t_ext();
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++; n_errs++;
    $display("FAIL watchdog R1 actual=%h expected=%h", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule